// File: doc/BRIEF.md
# Programmable Colour Matrix Converter

This block converts a stream of three-component 8-bit pixels through a programmable 3x3 signed matrix. Each output component is the weighted sum of the three inputs plus a per-channel signed offset. A common power-of-two gain is applied to the result, which is then rounded to nearest and clamped to 8 bits. Loaded with suitable parameter sets, the same datapath performs RGB to YCbCr conversion, YCbCr to RGB conversion, or an exact pass-through. A 2-bit gain field lets one datapath serve both coefficient precisions used by those sets: 1/256 per unit and 1/128 per unit.

Parameters are written as six 32-bit words into a shadow set. The shadow set is copied into the working set only on a frame-start strobe, so every pixel of a frame is computed with one consistent set. Pixels enter and leave through valid/ready handshakes. The pipeline has three register stages and a fixed latency, and the whole pipeline stalls when the consumer stalls.

Top module: `color_matrix_xform`

## Requirements
- R1: A write at address 2k (k = 0..2) sets output channel k's offset bits 4:0 from data bits 31:27, and sets three 9-bit coefficient fields from data bits 26:18 (field A), 17:9 (field B) and 8:0 (field C). A write at address 2k+1 sets offset bits 12:5 from data bits 7:0. Address 1 also carries the gain exponent in bits 9:8 and the saturation bit in bit 10. All other data bits are ignored, and writes to addresses 6 and 7 are ignored.
- R2: Coefficient M[r][c] weights input c (in_c0, in_c1, in_c2) into output r. Address 0 holds A=M[0][0], B=M[1][1], C=M[2][2]. Address 2 holds A=M[0][1], B=M[1][0], C=M[2][0]. Address 4 holds A=M[0][2], B=M[1][2], C=M[2][1]. Coefficients and offsets are two's complement.
- R3: Output r equals floor((S * 2^g + 256) / 512), where S = sum over c of M[r][c]*in_c + 64*offset[r] and g is the gain exponent (0..3). The sum is computed at full precision, and exact halves round upward.
- R4: Every output is clamped to 0..255 when the saturation bit is 0.
- R5: When the saturation bit is 1, every output is clamped to 16..235.
- R6: Parameter writes do not affect pixels until frame_start is high. A pixel accepted in the same cycle as frame_start uses the shadow set, and the shadow set stays in force from then on.
- R7: With out_ready held high, out_valid for a pixel accepted at clock edge k is high right after edge k+2.
- R8: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the outputs hold their values. Pixels leave in acceptance order, with none lost or duplicated.
- R9: After reset, out_valid is 0, in_ready is 1, and both parameter sets are all zero, so a pixel converted with them gives 0 on every output.
- R10: Gain exponent 2, 128 on the diagonal and zero elsewhere (including offsets) returns every input pixel unchanged.
- R11: Gain exponent 1, luma row 66/129/25 and luma offset 64 gives Y = round((66R+129G+25B)/256) + 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Parameter word write strobe |
| cfg_addr | input | 3 | Parameter word address |
| cfg_wdata | input | 32 | Parameter word data |
| frame_start | input | 1 | Copies the shadow set into the working set |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_c0 | input | 8 | Input component 0 |
| in_c1 | input | 8 | Input component 1 |
| in_c2 | input | 8 | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_c0 | output | 8 | Output component 0 |
| out_c1 | output | 8 | Output component 1 |
| out_c2 | output | 8 | Output component 2 |

## Verification
A coefficient decoded into the wrong matrix position, or a misplaced offset half, corrupts most pixels of a sweep at the very next frame start. It appears two cycles after the first pixel that uses the corrupted set. A rounding or gain-shift error shows as off-by-one or doubled values on a large fraction of a dense grid, and a clamp error shows only at the grid's extremes. For that reason the sweeps cover sets that drive sums far past both rails. A stage-valid or stall fault shows as a missing, repeated or reordered pixel at the first backpressure gap, or as a latency other than two edges after acceptance.

// File: rtl/color_matrix_xform.sv
module color_matrix_xform (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        frame_start,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_c0,
  input  logic [7:0]  in_c1,
  input  logic [7:0]  in_c2,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_c0,
  output logic [7:0]  out_c1,
  output logic [7:0]  out_c2
);
  localparam int PW   = 8;
  localparam int CW   = 9;
  localparam int OW   = 13;
  localparam int NCH  = 3;
  localparam int PRW  = PW + CW + 1;
  localparam int AW   = PRW + 6;
  localparam int OSH  = 6;
  localparam int FRAC = 9;

  typedef struct packed {
    logic                          sat;
    logic [1:0]                    sc;
    logic [NCH-1:0][OW-1:0]        off;
    logic [NCH-1:0][3*CW-1:0]      trip;
  } cset_t;

  cset_t sh, ac, ef;
  logic  v1, v2, ov, adv;

  assign adv       = !ov || out_ready;
  assign in_ready  = adv;
  assign out_valid = ov;
  assign ef        = frame_start ? sh : ac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      ov <= 1'b0;
      sh <= '0;
      ac <= '0;
    end else begin
      if (adv) begin
        v1 <= in_valid;
        v2 <= v1;
        ov <= v2;
      end
      for (int k = 0; k < NCH; k++) begin
        if (cfg_we && cfg_addr == 3'(2*k)) begin
          sh.trip[k]     <= cfg_wdata[3*CW-1:0];
          sh.off[k][4:0] <= cfg_wdata[31:27];
        end
        if (cfg_we && cfg_addr == 3'(2*k+1)) begin
          sh.off[k][OW-1:5] <= cfg_wdata[7:0];
          if (k == 0) {sh.sat, sh.sc} <= cfg_wdata[10:8];
        end
      end
      if (frame_start) ac <= sh;
    end
  end

  logic signed [CW-1:0] m [NCH][NCH];
  always_comb begin
    m[0][0] = ef.trip[0][3*CW-1:2*CW];
    m[1][1] = ef.trip[0][2*CW-1:CW];
    m[2][2] = ef.trip[0][CW-1:0];
    m[0][1] = ef.trip[1][3*CW-1:2*CW];
    m[1][0] = ef.trip[1][2*CW-1:CW];
    m[2][0] = ef.trip[1][CW-1:0];
    m[0][2] = ef.trip[2][3*CW-1:2*CW];
    m[1][2] = ef.trip[2][2*CW-1:CW];
    m[2][1] = ef.trip[2][CW-1:0];
  end

  logic [NCH-1:0][PW-1:0] px;
  assign px = {in_c2, in_c1, in_c0};

  logic signed [PRW-1:0] p1 [NCH][NCH];
  logic signed [OW-1:0]  o1 [NCH];
  logic [1:0]            sc1, sc2;
  logic                  sat1, sat2, sat3;
  logic signed [AW-1:0]  s2 [NCH];
  logic [NCH-1:0][PW-1:0] oc;
  logic [3:0]            shamt;
  logic signed [AW-1:0]  rnd [NCH];
  logic signed [AW-1:0]  q [NCH];
  logic signed [AW-1:0]  lo, hi;
  logic [PW-1:0]         yv [NCH];

  assign shamt = 4'(FRAC) - {2'b00, sc2};
  assign lo    = sat2 ? AW'(16)  : AW'(0);
  assign hi    = sat2 ? AW'(235) : AW'(255);

  always_comb begin
    for (int r = 0; r < NCH; r++) begin
      rnd[r] = s2[r] + (AW'(1) <<< (shamt - 4'd1));
      q[r]   = rnd[r] >>> shamt;
      if (q[r] < lo)      yv[r] = lo[PW-1:0];
      else if (q[r] > hi) yv[r] = hi[PW-1:0];
      else                yv[r] = q[r][PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int r = 0; r < NCH; r++) begin
        for (int c = 0; c < NCH; c++)
          p1[r][c] <= m[r][c] * $signed({1'b0, px[c]});
        o1[r] <= ef.off[r];
        s2[r] <= AW'(p1[r][0]) + AW'(p1[r][1]) + AW'(p1[r][2]) + (AW'(o1[r]) <<< OSH);
        oc[r] <= yv[r];
      end
      sc1  <= ef.sc;
      sat1 <= ef.sat;
      sc2  <= sc1;
      sat2 <= sat1;
      sat3 <= sat2;
    end
  end

  assign out_c0 = oc[0];
  assign out_c1 = oc[1];
  assign out_c2 = oc[2];

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !out_ready) |=> (ov && $stable(oc)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> ov);

  assert_sat_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && sat3) |-> (oc[0] >= 8'd16 && oc[0] <= 8'd235 &&
                      oc[1] >= 8'd16 && oc[1] <= 8'd235 &&
                      oc[2] >= 8'd16 && oc[2] <= 8'd235));

  assert_frame_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(ac));
endmodule

// File: tb/color_matrix_xform_tb.sv
module color_matrix_xform_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_c0, out_c1, out_c2;

  color_matrix_xform u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic bp_en = 1'b0;
  logic [7:0] lf = 8'h5a;
  int nm[3][3], no[3], nsc, nst;
  int pm[3][3], po[3], psc, pst;
  int am[3][3], ao[3], asc, ast;
  int q_e0[$], q_e1[$], q_e2[$], q_st[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    out_ready <= bp_en ? lf[0] : 1'b1;
  end

  always @(negedge clk) begin : mon
    int e0, e1, e2, st;
    string tg;
    #3;
    if (rst_n && out_valid && out_ready) begin
      if (q_e0.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8: output %0d/%0d/%0d with nothing expected", out_c0, out_c1, out_c2);
      end else begin
        e0 = q_e0.pop_front(); e1 = q_e1.pop_front(); e2 = q_e2.pop_front();
        st = q_st.pop_front(); tg = q_tag.pop_front();
        n_tests++;
        if (out_c0 != 8'(e0) || out_c1 != 8'(e1) || out_c2 != 8'(e2)) begin
          n_fail++;
          $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d",
                   tg, out_c0, out_c1, out_c2, e0, e1, e2);
        end
        if (!bp_en) begin
          n_tests++;
          if (cyc - st != 3) begin
            n_fail++;
            $display("FAIL R7: latency %0d expected 3", cyc - st);
          end
        end
      end
    end
  end

  function automatic int ev(int r, int a, int b, int c);
    int acc, lo, hi;
    acc = am[r][0]*a + am[r][1]*b + am[r][2]*c + 64*ao[r];
    acc = acc * (1 << asc);
    acc = (acc + 256) >>> 9;
    lo = ast ? 16 : 0;
    hi = ast ? 235 : 255;
    if (acc < lo) acc = lo;
    if (acc > hi) acc = hi;
    return acc;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setn(input int m00, input int m01, input int m02,
                      input int m10, input int m11, input int m12,
                      input int m20, input int m21, input int m22,
                      input int o0, input int o1, input int o2,
                      input int sc, input int st);
    nm[0][0] = m00; nm[0][1] = m01; nm[0][2] = m02;
    nm[1][0] = m10; nm[1][1] = m11; nm[1][2] = m12;
    nm[2][0] = m20; nm[2][1] = m21; nm[2][2] = m22;
    no[0] = o0; no[1] = o1; no[2] = o2; nsc = sc; nst = st;
  endtask

  task automatic load_pending();
    wr(0, {5'(no[0]), 9'(nm[0][0]), 9'(nm[1][1]), 9'(nm[2][2])});
    wr(1, {21'h1ABCD, 1'(nst), 2'(nsc), 8'(no[0] >>> 5)});
    wr(2, {5'(no[1]), 9'(nm[0][1]), 9'(nm[1][0]), 9'(nm[2][0])});
    wr(3, {24'hC3A5F0, 8'(no[1] >>> 5)});
    wr(4, {5'(no[2]), 9'(nm[0][2]), 9'(nm[1][2]), 9'(nm[2][1])});
    wr(5, {24'h5F0A3C, 8'(no[2] >>> 5)});
    pm = nm; po = no; psc = nsc; pst = nst;
  endtask

  task automatic fs_only();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    am = pm; ao = po; asc = psc; ast = pst;
  endtask

  task automatic send(input int a, input int b, input int c, input logic fs, input string tg);
    @(negedge clk);
    in_valid = 1'b1; in_c0 = 8'(a); in_c1 = 8'(b); in_c2 = 8'(c); frame_start = fs;
    #2;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    if (fs) begin am = pm; ao = po; asc = psc; ast = pst; end
    q_e0.push_back(ev(0, a, b, c)); q_e1.push_back(ev(1, a, b, c)); q_e2.push_back(ev(2, a, b, c));
    q_st.push_back(cyc); q_tag.push_back(tg);
    @(posedge clk); #1;
    in_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic sweep(input int n, input int step, input int base, input string tg);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        for (int k = 0; k < n; k++)
          send(base + i*step, base + j*step, base + k*step, 1'b0, tg);
  endtask

  task automatic drain();
    int k = 0;
    while (q_e0.size() != 0 && k < 2000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    repeat (130000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run reached %0d cycles expected completion earlier", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    setn(0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0);
    pm = nm; po = no; psc = 0; pst = 0;
    am = nm; ao = no; asc = 0; ast = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    n_tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R9: out_valid=%0b in_ready=%0b expected 0/1", out_valid, in_ready);
    end
    fs_only();
    send(200, 100, 50, 1'b0, "R9 zero set");
    drain();

    setn(128,0,0, 0,128,0, 0,0,128, 0,0,0, 2,0);
    load_pending(); fs_only();
    sweep(16, 17, 0, "R1 R2 R10 identity");
    drain();

    setn(66,129,25, -38,-74,112, 112,-94,-18, 64,512,512, 1,0);
    load_pending();
    send(10, 200, 90, 1'b0, "R6 before frame start");
    send(255, 0, 128, 1'b0, "R6 before frame start");
    wr(6, 32'hFFFFFFFF); wr(7, 32'hFFFFFFFF);
    send(33, 44, 55, 1'b0, "R6 before frame start");
    send(10, 20, 30, 1'b1, "R6 same-cycle frame start");
    sweep(16, 17, 0, "R3 R11 rgb to ycbcr");
    drain();

    fs_only();
    send(77, 140, 210, 1'b0, "R1 addresses 6 and 7 ignored");
    drain();

    setn(149,0,204, 149,-50,-104, 149,255,0, -446,266,-554, 2,0);
    load_pending(); fs_only();
    sweep(16, 17, 0, "R3 R4 ycbcr to rgb");
    drain();

    setn(149,0,204, 149,-50,-104, 149,255,0, -446,266,-554, 2,1);
    load_pending(); fs_only();
    sweep(16, 17, 0, "R5 saturation range");
    drain();

    bp_en = 1'b1;
    setn(255,-256,100, -200,60,255, 0,-1,-256, 4095,-4096,1000, 3,0);
    load_pending(); fs_only();
    sweep(8, 36, 3, "R4 R8 clamp under backpressure");
    setn(255,255,255, -100,200,-50, 128,-128,64, 0,2000,-3000, 0,0);
    load_pending(); fs_only();
    sweep(8, 36, 3, "R3 R8 gain 0 under backpressure");
    drain();
    bp_en = 1'b0;
    drain();

    n_tests++;
    if (q_e0.size() != 0) begin
      n_fail++;
      $display("FAIL R8: %0d pixels never emerged expected 0", q_e0.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule